// File: doc/BRIEF.md
# Halt-and-Transfer Calendar Clock Registers

This block is a calendar clock whose live time-of-day and date counters are kept apart from a bank of bus-visible registers. The visible bank sits in the last eight byte addresses of a 13-bit address space. Address 1FF8h holds a two-bit mode register, and seven time registers follow it. The live counters advance on a one-cycle tick that arrives once per second. While no halt is active, the visible bank copies the counters on every clock cycle.

Software reads a coherent time by setting the freeze bit. The visible bank then holds the value it had when the halt took effect, and the counters keep running underneath. Software sets the time by raising the load bit and writing the time registers. It then clears the load bit, and that clear copies all seven registers into the live counters in one cycle. All time values use packed BCD on a 24-hour clock.

Top module: `rtcHaltXfer`

## Requirements
- R1: After reset the mode register reads 00h and the time reads 00:00:00, day-of-week 01h, date 01h, month 01h, year 00h.
- R2: Read data is combinational from the address. The addresses are 1FF8h mode, 1FF9h seconds, 1FFAh minutes, 1FFBh hours, 1FFCh day-of-week, 1FFDh date, 1FFEh month and 1FFFh year. Every other address reads 00h.
- R3: With no halt active, each tick advances the counters by one second, and the visible bank shows the counters one cycle later.
- R4: Seconds and minutes wrap from 59h to 00h and carry. Hours wrap from 23h to 00h and advance the day. Day-of-week runs 01h to 07h and then wraps to 01h. Year wraps from 99h to 00h.
- R5: The date wraps to 01h and the month advances after the last day of the month. Months 04h, 06h, 09h and 11h have 30 days, and the other months have 31 days. February has 29 days when the year is divisible by 4 and 28 days otherwise. Month 12h wraps to 01h and advances the year.
- R6: Mode bit 6 (freeze) holds the visible bank while it is 1. The counters keep counting, so after the bit clears the visible bank shows the advanced time within two cycles.
- R7: Mode bit 7 (load) holds the visible bank. Writes to the time registers take effect only while this bit is 1 and are ignored otherwise. A tick that arrives while the bit is 1 is dropped.
- R8: A mode write that clears the load bit while it is 1 copies all seven visible registers into the counters in one cycle. The new time is readable two cycles later.
- R9: Unused bits read as 0. Mode bits 5:0 always read 0. The written values are masked to 7Fh for seconds, 7Fh for minutes, 3Fh for hours, 07h for day-of-week, 3Fh for date, 1Fh for month and FFh for year.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| addr | input | 13 | Byte address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe for addr |
| rdData | output | 8 | Combinational read data for addr |

## Verification
A wrong carry or month-length term in the counters shows up only when a tick crosses that boundary. It is visible in the matching register one cycle after the tick. A halt that leaks shows up as a visible register that changes between two reads taken while the freeze or load bit is set. A transfer that is lost or partial shows up as a wrong value in the affected time register two cycles after the load bit clears. A tick that is not dropped shows up as a seconds value one higher than the one loaded.

// File: rtl/rtcHaltPkg.sv
package rtcHaltPkg;
  localparam int NUM_TIME = 7;

  typedef logic [NUM_TIME-1:0][7:0] timeBank_t;

  typedef struct packed {
    logic       haltVis;
    logic       tickEn;
    logic       commit;
    logic       wrTime;
    logic [2:0] wrIdx;
  } rtcStrb_t;

  function automatic logic [7:0] fieldMask(int unsigned idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 4:    return 8'h3F;
      3:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leapYear(logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] monthLen(logic [7:0] mon, logic [7:0] yr);
    case (mon)
      8'h02:                      return leapYear(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcHaltPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        modeIn,
  input  logic              wrEn,
  output rtcStrb_t          strb,
  output logic [1:0]        modeBits
);
  localparam int SUB_W = ADDR_W - 3;

  logic readBit, writeBit;
  logic inTop, ctrlWr;

  assign inTop  = (addr[ADDR_W-1:3] == {SUB_W{1'b1}});
  assign ctrlWr = wrEn && inTop && (addr[2:0] == 3'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readBit  <= 1'b0;
      writeBit <= 1'b0;
    end else if (ctrlWr) begin
      writeBit <= modeIn[1];
      readBit  <= modeIn[0];
    end
  end

  always_comb begin
    strb.haltVis = readBit | writeBit;
    strb.tickEn  = secTick & ~writeBit;
    strb.commit  = ctrlWr & writeBit & ~modeIn[1];
    strb.wrTime  = wrEn & writeBit & inTop & (addr[2:0] != 3'd0);
    strb.wrIdx   = addr[2:0] - 3'd1;
  end

  assign modeBits = {writeBit, readBit};

  // R8: a transfer always leaves the load bit clear
  p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !writeBit);
  // R7: time writes never land while the load bit was clear
  p_no_write_unloaded_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !writeBit) |-> !strb.wrTime);
endmodule

// File: rtl/rtcData.sv
module rtcData
  import rtcHaltPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rtcStrb_t   strb,
  input  logic [7:0] wrData,
  output timeBank_t  vis
);
  timeBank_t cnt, cntNext, rstVal;
  logic secWrap, minWrap, hourWrap, dateWrap, monWrap;

  assign rstVal = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  always_comb begin
    secWrap  = (cnt[0] == 8'h59);
    minWrap  = secWrap && (cnt[1] == 8'h59);
    hourWrap = minWrap && (cnt[2] == 8'h23);
    dateWrap = hourWrap && (cnt[4] == monthLen(cnt[5], cnt[6]));
    monWrap  = dateWrap && (cnt[5] == 8'h12);
    cntNext  = cnt;
    cntNext[0] = secWrap ? 8'h00 : bcdInc(cnt[0]);
    if (secWrap) cntNext[1] = (cnt[1] == 8'h59) ? 8'h00 : bcdInc(cnt[1]);
    if (minWrap) cntNext[2] = (cnt[2] == 8'h23) ? 8'h00 : bcdInc(cnt[2]);
    if (hourWrap) begin
      cntNext[3] = (cnt[3] == 8'h07) ? 8'h01 : cnt[3] + 8'h01;
      cntNext[4] = dateWrap ? 8'h01 : bcdInc(cnt[4]);
    end
    if (dateWrap) cntNext[5] = monWrap ? 8'h01 : bcdInc(cnt[5]);
    if (monWrap)  cntNext[6] = (cnt[6] == 8'h99) ? 8'h00 : bcdInc(cnt[6]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= rstVal;
    else if (strb.commit) cnt <= vis;
    else if (strb.tickEn) cnt <= cntNext;
  end

  for (genvar g = 0; g < NUM_TIME; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)
        vis[g] <= rstVal[g];
      else if (strb.wrTime && strb.wrIdx == 3'(g))
        vis[g] <= wrData & fieldMask(g);
      else if (!strb.haltVis)
        vis[g] <= cnt[g];
    end
  end

  // R3: the visible bank follows the counters by one cycle
  p_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.haltVis && !strb.wrTime) |=> vis == $past(cnt));
  // R6: the visible bank holds while halted
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.haltVis && !strb.wrTime) |=> $stable(vis));
  // R8: a transfer loads every register at once
  p_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> cnt == $past(vis));
  // R7: without a tick or transfer the counters stand still
  p_drop_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !strb.tickEn) |=> $stable(cnt));
  // R4: seconds wrap to zero
  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tickEn && !strb.commit && cnt[0] == 8'h59) |=> cnt[0] == 8'h00);
endmodule

// File: rtl/rtcHaltXfer.sv
module rtcHaltXfer
  import rtcHaltPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  output logic [7:0]        rdData
);
  localparam int SUB_W = ADDR_W - 3;

  rtcStrb_t   strb;
  logic [1:0] modeBits;
  timeBank_t  vis;
  logic       inTop;

  rtcCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr),
    .modeIn(wrData[7:6]), .wrEn(wrEn), .strb(strb), .modeBits(modeBits)
  );

  rtcData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .vis(vis)
  );

  assign inTop = (addr[ADDR_W-1:3] == {SUB_W{1'b1}});

  always_comb begin
    rdData = 8'h00;
    if (inTop) begin
      if (addr[2:0] == 3'd0) rdData = {modeBits, 6'b0};
      else                   rdData = vis[addr[2:0] - 3'd1];
    end
  end

  // R9: mode register low bits never read as 1
  p_mode_low_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inTop && addr[2:0] == 3'd0) |-> rdData[5:0] == 6'd0);
  // R2: addresses outside the bank read zero
  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inTop |-> rdData == 8'h00);
endmodule

// File: tb/rtcHaltXfer_bench.sv
module rtcHaltXfer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic [12:0] addr = 13'h0;
  logic [7:0]  wrData = 8'h0;
  logic        wrEn = 1'b0;
  logic [7:0]  rdData;

  int errors = 0;
  int checks = 0;
  int m[7];
  int s[7];

  rtcHaltXfer u_rtcHaltXfer (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdData(rdData)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] bcd(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction

  function automatic int daysIn(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    m[0]++;
    if (m[0] == 60) begin
      m[0] = 0; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 24) begin
          m[2] = 0;
          m[3] = (m[3] == 7) ? 1 : m[3] + 1;
          m[4]++;
          if (m[4] > daysIn(m[5], m[6])) begin
            m[4] = 1; m[5]++;
            if (m[5] == 13) begin
              m[5] = 1; m[6] = (m[6] + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic wr(logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic checkTime(string req, int e[7]);
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(13'h1FF9 + 13'(i), d);
      check(req, d, bcd(e[i]));
    end
  endtask

  task automatic setTime(int t[7]);
    wr(13'h1FF8, 8'h80);
    for (int i = 0; i < 7; i++) wr(13'h1FF9 + 13'(i), bcd(t[i]));
    wr(13'h1FF8, 8'h00);
    settle();
    m = t;
  endtask

  task automatic edgeCase(string req, int t[7]);
    setTime(t);
    checkTime("R8 load", m);
    tick(); modelTick(); settle();
    checkTime(req, m);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 out-of-bank reads
    m = '{0, 0, 0, 1, 1, 1, 0};
    rd(13'h1FF8, d); check("R1 mode", d, 8'h00);
    checkTime("R1", m);
    rd(13'h0000, d); check("R2 low addr", d, 8'h00);
    rd(13'h1FF7, d); check("R2 below bank", d, 8'h00);

    // R3 plain ticks
    tick(); modelTick(); tick(); modelTick(); settle();
    checkTime("R3", m);

    // R4 full rollover: 23:59:59 day 7, 31 Dec 99
    edgeCase("R4", '{59, 59, 23, 7, 31, 12, 99});
    edgeCase("R4 min carry", '{59, 59, 10, 3, 15, 6, 42});
    // R5 month lengths and leap years
    edgeCase("R5 leap 28", '{59, 59, 23, 2, 28, 2, 24});
    edgeCase("R5 leap 29", '{59, 59, 23, 3, 29, 2, 24});
    edgeCase("R5 non-leap", '{59, 59, 23, 2, 28, 2, 23});
    edgeCase("R5 30-day", '{59, 59, 23, 5, 30, 4, 10});
    edgeCase("R5 31-day", '{59, 59, 23, 5, 30, 1, 10});

    // R9 masks and mode low bits
    wr(13'h1FF8, 8'hBF);
    rd(13'h1FF8, d); check("R9 mode", d, 8'h80);
    wr(13'h1FF9, 8'hFF); rd(13'h1FF9, d); check("R9 sec mask", d, 8'h7F);
    wr(13'h1FFB, 8'hFF); rd(13'h1FFB, d); check("R9 hour mask", d, 8'h3F);
    wr(13'h1FFC, 8'hFF); rd(13'h1FFC, d); check("R9 dow mask", d, 8'h07);
    wr(13'h1FFE, 8'hFF); rd(13'h1FFE, d); check("R9 month mask", d, 8'h1F);
    // R7 tick during load is dropped
    for (int i = 0; i < 7; i++) wr(13'h1FF9 + 13'(i), bcd(m[i]));
    tick();
    wr(13'h1FF8, 8'h00); settle();
    checkTime("R7 tick dropped", m);

    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) begin
        int n;
        n = int'($urandom % 5) + 1;
        for (int k = 0; k < n; k++) begin tick(); modelTick(); end
        settle();
        checkTime("R3 random", m);
      end else if (op == 1) begin
        int n;
        wr(13'h1FF8, 8'h40);
        s = m;
        n = int'($urandom % 4) + 1;
        for (int k = 0; k < n; k++) begin tick(); modelTick(); end
        checkTime("R6 frozen", s);
        wr(13'h1FF8, 8'h00); settle();
        checkTime("R6 resumed", m);
      end else if (op == 2) begin
        int t[7];
        t[6] = int'($urandom % 100);
        t[5] = int'($urandom % 12) + 1;
        t[4] = int'($urandom % daysIn(t[5], t[6])) + 1;
        t[3] = int'($urandom % 7) + 1;
        t[2] = int'($urandom % 24);
        t[1] = int'($urandom % 60);
        t[0] = int'($urandom % 60);
        setTime(t);
        checkTime("R8 random", m);
      end else begin
        wr(13'h1FF9 + 13'($urandom % 7), 8'($urandom));
        settle();
        checkTime("R7 ignored", m);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule